// File: doc/BRIEF.md
# Raster Timing Generator with Plane Windows

This block produces the raster timing for a display pipe, clocked by the pixel clock. A horizontal and a vertical counter sweep from zero up to a programmed frame corner and then wrap, so the whole frame geometry comes from corner coordinates and not from porch and sync lengths. Around that sweep the block decodes one active display window and three plane windows. Each window is given by an upper-left and a lower-right corner. From these it drives a display-enable output and one enable per plane channel.

The same sweep drives active-high horizontal and vertical sync, using two programmable sync widths. It also raises single-cycle pulses on two programmed lines, which a context loader uses to time its single-buffered and double-buffered updates. Configuration arrives through a write-only port, one 32-bit word per address. Every output is registered, so each one is aligned with the counter values shown on `pixX`/`pixY`.

Top module: `disp_timing_gen`

## Requirements
- R1: While running, `pixX` counts up by one each cycle. After the cycle in which it equals the frame X corner (address 1, bits [12:0]) it returns to 0, and `pixY` then advances. After the last column of the row equal to the frame Y corner (address 1, bits [28:16]), `pixY` returns to 0.
- R2: Control word bit 8 (address 0) is the start bit. While it is clear, the counters are held at zero, and from the second cycle after it clears every output is 0.
- R3: `dispEn` is 1 exactly when `pixX` and `pixY` lie inclusively between the display upper-left corner (address 2) and the display lower-right corner (address 3). Each corner word holds X in bits [12:0] and Y in bits [28:16].
- R4: `chanEn[i]` is 1 exactly when the position lies inclusively inside plane window i and that channel's control bit is set. Window i has its upper-left corner at address 4+2i and its lower-right corner at address 5+2i. The control bits are bit 2 for i=0, bit 1 for i=1 and bit 0 for i=2.
- R5: A plane window whose two corner words both have all-zero coordinate fields is empty, and that channel's enable stays 0 whatever its control bit.
- R6: `hSync` is 1 while `pixX` is below the horizontal sync width (address 11, bits [12:0]). `vSync` is 1 while `pixY` is below the vertical sync width (address 11, bits [28:16]).
- R7: `dbTrig` pulses for exactly one cycle, when `pixX` is 0 and `pixY` equals the double-buffer trigger line (address 10, bits [12:0]).
- R8: `sbTrig` pulses for exactly one cycle, when `pixX` is 0 and `pixY` equals the single-buffer trigger line (address 10, bits [28:16]).
- R9: After reset, all outputs are 0 and all configuration words read as zero, so the generator is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration word address |
| cfgWData | input | 32 | Configuration write data |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| dispEn | output | 1 | Inside active display window |
| chanEn | output | 3 | Per-plane enable, bit 0 = channel 1 |
| sbTrig | output | 1 | Single-buffer context-load pulse |
| dbTrig | output | 1 | Double-buffer context-load pulse |
| pixX | output | 13 | Horizontal position matching the other outputs |
| pixY | output | 13 | Vertical position matching the other outputs |

## Verification
Four frame geometries are loaded from a table and swept over two full frames each, and every output is compared against a bench-side counter model on every cycle.

- **Window placement.** The table mixes a window in the frame interior, a window that covers the whole frame, a window reaching beyond the display area, single-pixel and single-column windows, and an empty window on an enabled channel. Together these separate the inclusive bounds from exclusive ones and window matching from the channel enable bits.
- **Sync widths.** The widths are 0, a mid-range value and a value larger than the frame, which separates "never", "partial" and "always" sync.
- **Trigger lines.** The two trigger lines are placed on different rows and on the same row, and at the first and last rows, so that the bit fields of the trigger word are told apart.
- **Stop and restart.** Between vectors the generator is stopped, which checks the hold at zero.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  parameter int COORD_W = 13;
  parameter int NUM_CH  = 3;
  parameter int ADDR_W  = 4;
  parameter int DATA_W  = 32;

  localparam int Y_LSB     = 16;
  localparam int START_BIT = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FRAME   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DTOP    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DBOT    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CH_BASE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TRIG    = ADDR_W'(4 + 2*NUM_CH);
  localparam logic [ADDR_W-1:0] A_SYNC    = ADDR_W'(5 + 2*NUM_CH);

  typedef struct packed {
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] x;
  } dtg_pt_t;

  typedef struct packed {
    logic                            start;
    logic [NUM_CH-1:0]               chOn;
    dtg_pt_t                         frameEnd;
    dtg_pt_t                         dispTl;
    dtg_pt_t                         dispBr;
    dtg_pt_t [NUM_CH-1:0]            chTl;
    dtg_pt_t [NUM_CH-1:0]            chBr;
    logic [COORD_W-1:0]              dbLine;
    logic [COORD_W-1:0]              sbLine;
    logic [COORD_W-1:0]              hSyncW;
    logic [COORD_W-1:0]              vSyncW;
  } dtg_cfg_t;

  typedef struct packed {
    logic run;
    logic lineStart;
  } dtg_strobe_t;

  function automatic dtg_pt_t unpackPt(input logic [DATA_W-1:0] w);
    dtg_pt_t p;
    p.x = w[COORD_W-1:0];
    p.y = w[Y_LSB+COORD_W-1:Y_LSB];
    return p;
  endfunction
endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [DATA_W-1:0]   cfgWData,
  output dtg_cfg_t            cfgQ,
  output dtg_strobe_t         strobe,
  output logic [COORD_W-1:0]  hCnt,
  output logic [COORD_W-1:0]  vCnt
);
  logic unusedWr;
  assign unusedWr = ^{cfgWData[DATA_W-1:Y_LSB+COORD_W], cfgWData[Y_LSB-1:COORD_W]};

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == A_CTRL) begin
        cfgQ.start <= cfgWData[START_BIT];
        for (int i = 0; i < NUM_CH; i++) cfgQ.chOn[i] <= cfgWData[NUM_CH-1-i];
      end
      if (cfgAddr == A_FRAME) cfgQ.frameEnd <= unpackPt(cfgWData);
      if (cfgAddr == A_DTOP)  cfgQ.dispTl   <= unpackPt(cfgWData);
      if (cfgAddr == A_DBOT)  cfgQ.dispBr   <= unpackPt(cfgWData);
      for (int i = 0; i < NUM_CH; i++) begin
        if (cfgAddr == A_CH_BASE + ADDR_W'(2*i))     cfgQ.chTl[i] <= unpackPt(cfgWData);
        if (cfgAddr == A_CH_BASE + ADDR_W'(2*i + 1)) cfgQ.chBr[i] <= unpackPt(cfgWData);
      end
      if (cfgAddr == A_TRIG) begin
        cfgQ.dbLine <= cfgWData[COORD_W-1:0];
        cfgQ.sbLine <= cfgWData[Y_LSB+COORD_W-1:Y_LSB];
      end
      if (cfgAddr == A_SYNC) begin
        cfgQ.hSyncW <= cfgWData[COORD_W-1:0];
        cfgQ.vSyncW <= cfgWData[Y_LSB+COORD_W-1:Y_LSB];
      end
    end
  end

  // raster counters
  logic hLast, vLast;
  assign hLast = (hCnt >= cfgQ.frameEnd.x);
  assign vLast = (vCnt >= cfgQ.frameEnd.y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!cfgQ.start) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hLast) begin
      hCnt <= '0;
      vCnt <= vLast ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assign strobe.run       = cfgQ.start;
  assign strobe.lineStart = (hCnt == '0);

  AST_STOP_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgQ.start |=> (hCnt == '0 && vCnt == '0)); // R2
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ.start && hCnt < cfgQ.frameEnd.x) |=> (hCnt == $past(hCnt) + 1'b1)); // R1
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ.start && hCnt >= cfgQ.frameEnd.x) |=> (hCnt == '0)); // R1
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  dtg_cfg_t            cfg,
  input  dtg_strobe_t         strobe,
  input  logic [COORD_W-1:0]  hCnt,
  input  logic [COORD_W-1:0]  vCnt,
  output logic                hSync,
  output logic                vSync,
  output logic                dispEn,
  output logic [NUM_CH-1:0]   chanEn,
  output logic                sbTrig,
  output logic                dbTrig,
  output logic [COORD_W-1:0]  pixX,
  output logic [COORD_W-1:0]  pixY
);
  logic unusedDp;
  assign unusedDp = cfg.start ^ (^cfg.frameEnd);

  function automatic logic inWin(input logic [COORD_W-1:0] x, input logic [COORD_W-1:0] y,
                                 input dtg_pt_t tl, input dtg_pt_t br);
    return (x >= tl.x) && (x <= br.x) && (y >= tl.y) && (y <= br.y);
  endfunction

  logic              dispHit;
  logic [NUM_CH-1:0] chEmpty, chHit;

  assign dispHit = strobe.run && inWin(hCnt, vCnt, cfg.dispTl, cfg.dispBr);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chEmpty[i] = (cfg.chTl[i] == '0) && (cfg.chBr[i] == '0);
    assign chHit[i]   = strobe.run && cfg.chOn[i] && !chEmpty[i]
                        && inWin(hCnt, vCnt, cfg.chTl[i], cfg.chBr[i]);

    AST_CH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.chOn[i] |=> !chanEn[i]); // R4
    AST_CH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      chEmpty[i] |=> !chanEn[i]); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hSync  <= 1'b0;
      vSync  <= 1'b0;
      dispEn <= 1'b0;
      chanEn <= '0;
      sbTrig <= 1'b0;
      dbTrig <= 1'b0;
      pixX   <= '0;
      pixY   <= '0;
    end else begin
      hSync  <= strobe.run && (hCnt < cfg.hSyncW);
      vSync  <= strobe.run && (vCnt < cfg.vSyncW);
      dispEn <= dispHit;
      chanEn <= chHit;
      sbTrig <= strobe.run && strobe.lineStart && (vCnt == cfg.sbLine);
      dbTrig <= strobe.run && strobe.lineStart && (vCnt == cfg.dbLine);
      pixX   <= hCnt;
      pixY   <= vCnt;
    end
  end

  AST_DB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbTrig && hCnt != '0) |=> !dbTrig); // R7
  AST_SB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sbTrig && hCnt != '0) |=> !sbTrig); // R8
  AST_HSYNC_ZERO_W: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hSyncW == '0) |=> !hSync); // R6
  AST_DISP_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.run |=> !dispEn); // R2
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [DATA_W-1:0]          cfgWData,
  output logic                       hSync,
  output logic                       vSync,
  output logic                       dispEn,
  output logic [NUM_CH-1:0]          chanEn,
  output logic                       sbTrig,
  output logic                       dbTrig,
  output logic [COORD_W-1:0]         pixX,
  output logic [COORD_W-1:0]         pixY
);
  dtg_cfg_t           cfgQ;
  dtg_strobe_t        strobe;
  logic [COORD_W-1:0] hCnt, vCnt;

  dtg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWData(cfgWData),
    .cfgQ(cfgQ), .strobe(strobe), .hCnt(hCnt), .vCnt(vCnt)
  );

  dtg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfgQ), .strobe(strobe), .hCnt(hCnt), .vCnt(vCnt),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn), .chanEn(chanEn),
    .sbTrig(sbTrig), .dbTrig(dbTrig), .pixX(pixX), .pixY(pixY)
  );
endmodule

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWData = '0;
  logic        hSync, vSync, dispEn, sbTrig, dbTrig;
  logic [2:0]  chanEn;
  logic [12:0] pixX, pixY;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_timing_gen u_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWData(cfgWData),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn), .chanEn(chanEn),
    .sbTrig(sbTrig), .dbTrig(dbTrig), .pixX(pixX), .pixY(pixY)
  );

  function automatic logic [31:0] mk(input int y, input int x);
    return {3'd0, 13'(y), 3'd0, 13'(x)};
  endfunction

  // words per vector, by address: ctrl, frame, dTop, dBot, c1T, c1B, c2T, c2B, c3T, c3B, trig, sync
  localparam int NV = 4;
  localparam logic [31:0] VECS [NV][12] = '{
    '{32'h107, mk(7,11), mk(1,2), mk(6,9), mk(2,3), mk(4,5), mk(1,6), mk(6,9), 32'h0, 32'h0, mk(0,6), mk(1,2)},
    '{32'h102, mk(5,7),  mk(0,0), mk(5,7), mk(0,0), mk(1,1), mk(2,4), mk(5,7), mk(3,2), mk(3,3), mk(2,5), mk(0,0)},
    '{32'h105, mk(3,15), mk(0,4), mk(2,15), 32'h0, 32'h0, mk(1,1), mk(2,2), mk(1,10), mk(3,15), mk(3,3), mk(4,16)},
    '{32'h107, mk(9,5),  mk(2,1), mk(8,4), mk(2,1), mk(2,1), mk(0,0), mk(1,0), mk(5,2), mk(9,4), mk(1,9), mk(2,1)}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic inside2(input int x, input int y, input logic [31:0] tl, input logic [31:0] br);
    return x >= int'(tl[12:0]) && x <= int'(br[12:0]) && y >= int'(tl[28:16]) && y <= int'(br[28:16]);
  endfunction

  task automatic checkIdle(input string req);
    chk(req, {pixX, pixY}, 26'd0);
    chk(req, {hSync, vSync, dispEn, chanEn, sbTrig, dbTrig}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R9");                     // outputs low during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checkIdle("R9");                     // stopped after reset
    wr(4'd11, mk(3,3));                  // sync set but not started: R2 holds outputs low
    repeat (3) @(negedge clk);
    checkIdle("R2");

    for (int v = 0; v < NV; v++) begin
      int ex, ey, fx, fy, cyc;
      wr(4'd0, 32'h0);                   // stop
      repeat (2) @(negedge clk);
      checkIdle("R2");
      for (int a = 1; a < 12; a++) wr(4'(a), VECS[v][a]);
      repeat (2) @(negedge clk);
      checkIdle("R2");                   // configured but stopped
      wr(4'd0, VECS[v][0]);
      fx = int'(VECS[v][1][12:0]);
      fy = int'(VECS[v][1][28:16]);
      ex = 0; ey = 0;
      cyc = 2 * (fx + 1) * (fy + 1) + 3;
      for (int c = 0; c < cyc; c++) begin
        @(negedge clk);
        chk("R1", {19'd0, pixX}, 32'(ex));
        chk("R1", {19'd0, pixY}, 32'(ey));
        chk("R3", {31'd0, dispEn}, {31'd0, inside2(ex, ey, VECS[v][2], VECS[v][3])});
        for (int i = 0; i < 3; i++) begin
          logic empty, exp;
          empty = (VECS[v][4+2*i] & 32'h1FFF1FFF) == 0 && (VECS[v][5+2*i] & 32'h1FFF1FFF) == 0;
          exp = VECS[v][0][2-i] && !empty && inside2(ex, ey, VECS[v][4+2*i], VECS[v][5+2*i]);
          chk(empty ? "R5" : "R4", {31'd0, chanEn[i]}, {31'd0, exp});
        end
        chk("R6", {31'd0, hSync}, {31'd0, ex < int'(VECS[v][11][12:0])});
        chk("R6", {31'd0, vSync}, {31'd0, ey < int'(VECS[v][11][28:16])});
        chk("R7", {31'd0, dbTrig}, {31'd0, ex == 0 && ey == int'(VECS[v][10][12:0])});
        chk("R8", {31'd0, sbTrig}, {31'd0, ex == 0 && ey == int'(VECS[v][10][28:16])});
        if (ex == fx) begin
          ex = 0;
          ey = (ey == fy) ? 0 : ey + 1;
        end else begin
          ex = ex + 1;
        end
      end
    end

    wr(4'd0, 32'h0);
    repeat (2) @(negedge clk);
    checkIdle("R2");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule